// File: doc/BRIEF.md
# Coordinated Second-Order Step Segment Generator

This block turns one move segment into step and direction signals for a group of motors that move together. Each motor runs a digital differential analyzer with a second-order term. On every DDA tick a per-motor acceleration term is added to the motor's rate. The rate is then added to a 64-bit substep accumulator. Each time the accumulator overflows, the motor takes one step. Every motor in the group shares one segment length, counted in DDA ticks, so the whole group starts and ends a segment on the same tick.

A host presents a segment on the load inputs and pulses `seg_load`. The segment is parked in a pending slot. It begins on the first DDA tick on which no segment is running, so a host can queue the next segment while the current one is still running and get no gap between them. The block keeps a signed absolute step count for each motor as its shaft position. The effector position outputs carry zero, because no encoder is attached.

DDA ticks come in as a clock enable (`tick_en`) on the system clock. For example, a 16 MHz tick rate with a length of 16000 ticks gives a 1 ms segment.

Top module: `dda_seg_gen`

## Requirements
- R1: After reset, every step and direction output is 0, every shaft position is 0, `seg_done` is 0 and `busy` is 0.
- R2: On each running tick, every motor first adds its acceleration term to its rate, then adds the new rate to its 64-bit accumulator. A carry out of accumulator bit 63 raises that motor's step output. A tick with no carry lowers it.
- R3: A step output stays at its value from one DDA tick to the next. Clock cycles in which `tick_en` is low change no output.
- R4: Motor m's shaft position is a signed 32-bit count at bits [32m+31:32m] of `shaft_pos`. A step with direction 0 adds 1 to it, and a step with direction 1 subtracts 1.
- R5: `effector_pos` is zero in every cycle.
- R6: The tick that starts a segment loads rate, acceleration and direction (bit m of `seg_dir` is motor m's direction) and produces no step. Stepping then runs for exactly `seg_ticks` ticks, so a direction change is always visible at least one tick before the first step in the new direction.
- R7: `seg_done` is high for one clock after the tick on which the remaining tick count reaches zero. A segment of length 0 raises `seg_done` on its start tick and produces no steps.
- R8: A segment loaded while another is running waits and starts on the first tick after the running one's final tick. A second load made before the pending segment starts replaces it.
- R9: The accumulators keep their values from one segment to the next; starting a segment does not clear them.
- R10: `busy` is high from the start tick of a segment of nonzero length until its final tick, and falls together with the rise of `seg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | DDA tick enable, one clock wide per tick |
| seg_load | input | 1 | Capture the segment inputs into the pending slot |
| seg_ticks | input | TICK_W | Segment length in DDA ticks |
| seg_dir | input | NUM_MOTORS | Per-motor direction, 0 forward, 1 reverse |
| seg_rate | input | NUM_MOTORS*64 | Per-motor starting rate (substep increment) |
| seg_accel | input | NUM_MOTORS*64 | Per-motor rate increment per tick |
| step_o | output | NUM_MOTORS | Step pulses |
| dir_o | output | NUM_MOTORS | Direction outputs |
| shaft_pos | output | NUM_MOTORS*32 | Signed absolute step counts |
| effector_pos | output | NUM_MOTORS*32 | Effector positions, always zero |
| seg_done | output | 1 | One-clock pulse at segment end |
| busy | output | 1 | Segment running |

## Verification
Every result is registered once on a tick edge. A segment captured at clock edge P0 therefore shows its start tick on the outputs after the first tick edge following P0. It shows its k-th stepping tick after the k-th tick edge after that, and `seg_done` appears together with the last stepping tick. The driver computes the whole tick-by-tick sequence of a segment just after the capture edge and appends it to a queue. The monitor samples one nanosecond after each clock edge and pops one entry only for edges at which `tick_en` was high. On edges without a tick, it checks that nothing moved. Because segments queued back to back are simply appended to the queue, the monitor also checks the cycle at which a pending segment takes over.

// File: rtl/dda_seg_pkg.sv
package dda_seg_pkg;
  localparam int ACC_W = 64;
  localparam int POS_W = 32;

  typedef logic [ACC_W-1:0] acc_t;
  typedef logic signed [POS_W-1:0] pos_t;

  typedef struct packed {
    acc_t acc;
    acc_t rate;
    logic carry;
  } dda_adv_t;

  // Second-order advance: rate grows first, then feeds the accumulator.
  function automatic dda_adv_t dda_advance(acc_t acc, acc_t rate, acc_t accel);
    dda_adv_t r;
    logic [ACC_W:0] sum;
    r.rate  = rate + accel;
    sum     = {1'b0, acc} + {1'b0, r.rate};
    r.acc   = sum[ACC_W-1:0];
    r.carry = sum[ACC_W];
    return r;
  endfunction

  function automatic pos_t pos_move(pos_t p, logic rev);
    return rev ? p - pos_t'(1) : p + pos_t'(1);
  endfunction
endpackage

// File: rtl/dda_seg_shadow.sv
module dda_seg_shadow
  import dda_seg_pkg::*;
#(
  parameter int NUM_MOTORS = 2,
  parameter int TICK_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        consume,
  input  logic [TICK_W-1:0]           in_ticks,
  input  logic [NUM_MOTORS-1:0]       in_dir,
  input  logic [NUM_MOTORS*ACC_W-1:0] in_rate,
  input  logic [NUM_MOTORS*ACC_W-1:0] in_accel,
  output logic                        pend_valid,
  output logic [TICK_W-1:0]           pend_ticks,
  output logic [NUM_MOTORS-1:0]       pend_dir,
  output logic [NUM_MOTORS*ACC_W-1:0] pend_rate,
  output logic [NUM_MOTORS*ACC_W-1:0] pend_accel
);
  // A new load wins over a consume in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_ticks <= '0;
      pend_dir   <= '0;
      pend_rate  <= '0;
      pend_accel <= '0;
    end else if (load) begin
      pend_valid <= 1'b1;
      pend_ticks <= in_ticks;
      pend_dir   <= in_dir;
      pend_rate  <= in_rate;
      pend_accel <= in_accel;
    end else if (consume) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dda_seg_ctrl.sv
module dda_seg_ctrl #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              pend_valid,
  input  logic [TICK_W-1:0] pend_ticks,
  output logic              start,
  output logic              run_tick,
  output logic [TICK_W-1:0] remaining,
  output logic              busy,
  output logic              seg_done
);
  logic last_tick;

  assign busy      = (remaining != '0);
  assign start     = tick_en && !busy && pend_valid;
  assign run_tick  = tick_en && busy;
  assign last_tick = run_tick && (remaining == TICK_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      seg_done  <= 1'b0;
    end else begin
      seg_done <= last_tick || (start && pend_ticks == '0);
      if (start)         remaining <= pend_ticks;
      else if (run_tick) remaining <= remaining - TICK_W'(1);
    end
  end
endmodule

// File: rtl/dda_axis.sv
module dda_axis
  import dda_seg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic start,
  input  logic run_tick,
  input  logic ld_dir,
  input  acc_t ld_rate,
  input  acc_t ld_accel,
  output logic step,
  output logic dir,
  output pos_t pos,
  output logic carry
);
  acc_t     acc_q, rate_q, accel_q;
  dda_adv_t nxt;

  assign nxt   = dda_advance(acc_q, rate_q, accel_q);
  assign carry = run_tick && nxt.carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      rate_q  <= '0;
      accel_q <= '0;
      dir     <= 1'b0;
      step    <= 1'b0;
      pos     <= '0;
    end else if (tick_en) begin
      if (start) begin
        rate_q  <= ld_rate;
        accel_q <= ld_accel;
        dir     <= ld_dir;
        step    <= 1'b0;
      end else if (run_tick) begin
        acc_q  <= nxt.acc;
        rate_q <= nxt.rate;
        step   <= nxt.carry;
        if (nxt.carry) pos <= pos_move(pos, dir);
      end else begin
        step <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dda_seg_gen.sv
module dda_seg_gen
  import dda_seg_pkg::*;
#(
  parameter int NUM_MOTORS = 2,
  parameter int TICK_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_en,
  input  logic                        seg_load,
  input  logic [TICK_W-1:0]           seg_ticks,
  input  logic [NUM_MOTORS-1:0]       seg_dir,
  input  logic [NUM_MOTORS*ACC_W-1:0] seg_rate,
  input  logic [NUM_MOTORS*ACC_W-1:0] seg_accel,
  output logic [NUM_MOTORS-1:0]       step_o,
  output logic [NUM_MOTORS-1:0]       dir_o,
  output logic [NUM_MOTORS*POS_W-1:0] shaft_pos,
  output logic [NUM_MOTORS*POS_W-1:0] effector_pos,
  output logic                        seg_done,
  output logic                        busy
);
  logic                        pend_valid;
  logic [TICK_W-1:0]           pend_ticks;
  logic [NUM_MOTORS-1:0]       pend_dir;
  logic [NUM_MOTORS*ACC_W-1:0] pend_rate, pend_accel;
  logic                        seg_start, seg_run_tick;
  logic [TICK_W-1:0]           seg_remaining;
  logic [NUM_MOTORS-1:0]       dda_carry;

  dda_seg_shadow #(.NUM_MOTORS(NUM_MOTORS), .TICK_W(TICK_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(seg_load), .consume(seg_start),
    .in_ticks(seg_ticks), .in_dir(seg_dir), .in_rate(seg_rate), .in_accel(seg_accel),
    .pend_valid(pend_valid), .pend_ticks(pend_ticks), .pend_dir(pend_dir),
    .pend_rate(pend_rate), .pend_accel(pend_accel)
  );

  dda_seg_ctrl #(.TICK_W(TICK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .pend_valid(pend_valid), .pend_ticks(pend_ticks),
    .start(seg_start), .run_tick(seg_run_tick), .remaining(seg_remaining),
    .busy(busy), .seg_done(seg_done)
  );

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_axis
    pos_t axis_pos;
    dda_axis u_axis (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .start(seg_start), .run_tick(seg_run_tick),
      .ld_dir(pend_dir[m]),
      .ld_rate(pend_rate[m*ACC_W +: ACC_W]),
      .ld_accel(pend_accel[m*ACC_W +: ACC_W]),
      .step(step_o[m]), .dir(dir_o[m]), .pos(axis_pos), .carry(dda_carry[m])
    );
    assign shaft_pos[m*POS_W +: POS_W] = axis_pos;
  end

  assign effector_pos = '0;
endmodule

// File: rtl/dda_seg_gen_chk.sv
module dda_seg_gen_chk #(
  parameter int NUM_MOTORS = 2,
  parameter int TICK_W     = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_en,
  input logic [NUM_MOTORS-1:0]  step_o,
  input logic [NUM_MOTORS-1:0]  dir_o,
  input logic [NUM_MOTORS*32-1:0] shaft_pos,
  input logic                   seg_done,
  input logic                   busy,
  input logic [TICK_W-1:0]      seg_remaining,
  input logic [NUM_MOTORS-1:0]  dda_carry
);
  p_done_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> !seg_done);

  p_busy_fall_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> seg_done);

  p_idle_no_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && seg_remaining == '0) |=> (step_o == '0));

  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_en) |-> ($stable(step_o) && $stable(dir_o) && $stable(shaft_pos)));

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_m
    p_carry_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && dda_carry[m]) |=> step_o[m]);

    p_pos_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shaft_pos[m*32 +: 32]) |-> step_o[m]);

    p_dir_before_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dir_o[m]) |-> !step_o[m]);
  end
endmodule

bind dda_seg_gen dda_seg_gen_chk #(.NUM_MOTORS(NUM_MOTORS), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step_o(step_o), .dir_o(dir_o),
  .shaft_pos(shaft_pos), .seg_done(seg_done), .busy(busy),
  .seg_remaining(seg_remaining), .dda_carry(dda_carry)
);

// File: tb/test_dda_seg_gen.sv
module test_dda_seg_gen;
  localparam int NM = 2;
  localparam int TW = 32;
  localparam int AW = 64;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic seg_load = 1'b0;
  logic [TW-1:0]    seg_ticks = '0;
  logic [NM-1:0]    seg_dir = '0;
  logic [NM*AW-1:0] seg_rate = '0, seg_accel = '0;
  logic [NM-1:0]    step_o, dir_o;
  logic [NM*PW-1:0] shaft_pos, effector_pos;
  logic             seg_done, busy;

  always #2 clk = ~clk;

  dda_seg_gen #(.NUM_MOTORS(NM), .TICK_W(TW)) i_dda_seg_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .seg_load(seg_load),
    .seg_ticks(seg_ticks), .seg_dir(seg_dir), .seg_rate(seg_rate), .seg_accel(seg_accel),
    .step_o(step_o), .dir_o(dir_o), .shaft_pos(shaft_pos), .effector_pos(effector_pos),
    .seg_done(seg_done), .busy(busy)
  );

  typedef struct {
    logic [NM-1:0]    step;
    logic [NM-1:0]    dir;
    logic [NM*PW-1:0] pos;
    logic             done;
    logic             busy;
  } item_t;

  item_t exp_q[$];
  item_t last_exp;
  int checks = 0;
  int failures = 0;
  bit slow_mode = 1'b0;
  bit finished = 1'b0;

  logic [AW-1:0] m_acc [NM];
  logic [AW-1:0] m_rate [NM];
  int            m_pos [NM];

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [NM*PW-1:0] pos_vec();
    logic [NM*PW-1:0] v;
    for (int m = 0; m < NM; m++) v[m*PW +: PW] = m_pos[m];
    return v;
  endfunction

  // Expected tick-by-tick results of one segment, pushed after its capture edge.
  task automatic plan_segment(int ticks, logic [NM-1:0] dir,
                              logic [NM*AW-1:0] rate, logic [NM*AW-1:0] accel);
    item_t it;
    it.step = '0; it.dir = dir; it.pos = pos_vec();
    it.done = (ticks == 0); it.busy = (ticks != 0);
    exp_q.push_back(it);
    for (int m = 0; m < NM; m++) m_rate[m] = rate[m*AW +: AW];
    for (int k = 1; k <= ticks; k++) begin
      for (int m = 0; m < NM; m++) begin
        logic [AW:0] wide;
        m_rate[m] = m_rate[m] + accel[m*AW +: AW];
        wide = {1'b0, m_acc[m]} + {1'b0, m_rate[m]};
        m_acc[m] = wide[AW-1:0];
        it.step[m] = wide[AW];
        if (wide[AW]) m_pos[m] = dir[m] ? m_pos[m] - 1 : m_pos[m] + 1;
      end
      it.pos = pos_vec(); it.done = (k == ticks); it.busy = (k != ticks);
      exp_q.push_back(it);
    end
  endtask

  task automatic load_seg(int ticks, logic [NM-1:0] dir,
                          logic [NM*AW-1:0] rate, logic [NM*AW-1:0] accel);
    @(negedge clk);
    seg_ticks = TW'(ticks); seg_dir = dir; seg_rate = rate; seg_accel = accel;
    seg_load = 1'b1;
    @(negedge clk);
    seg_load = 1'b0;
  endtask

  task automatic run_seg(int ticks, logic [NM-1:0] dir,
                         logic [NM*AW-1:0] rate, logic [NM*AW-1:0] accel);
    load_seg(ticks, dir, rate, accel);
    plan_segment(ticks, dir, rate, accel);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Tick enable generator
  initial forever begin
    @(negedge clk);
    tick_en = rst_n && (slow_mode ? !tick_en : 1'b1);
  end

  // Monitor: one expected entry per tick edge
  initial begin
    last_exp.step = '0; last_exp.dir = '0; last_exp.pos = '0;
    last_exp.done = 1'b0; last_exp.busy = 1'b0;
    forever begin
      bit t;
      @(posedge clk);
      t = tick_en;
      #1;
      if (rst_n && !finished) begin
        check(effector_pos == '0, "R5", "effector_pos", 128'(effector_pos), 128'(0));
        if (t && exp_q.size() != 0) begin
          item_t e;
          e = exp_q.pop_front();
          check(step_o == e.step, "R2", "step_o", 128'(step_o), 128'(e.step));
          check(shaft_pos == e.pos, "R4", "shaft_pos", 128'(shaft_pos), 128'(e.pos));
          check(dir_o == e.dir, "R6", "dir_o", 128'(dir_o), 128'(e.dir));
          check(seg_done == e.done, "R7", "seg_done", 128'(seg_done), 128'(e.done));
          check(busy == e.busy, "R10", "busy", 128'(busy), 128'(e.busy));
          last_exp = e;
        end else if (t) begin
          check(step_o == '0 && !seg_done && !busy, "R6", "idle tick outputs",
                128'({step_o, seg_done, busy}), 128'(0));
          check(shaft_pos == last_exp.pos && dir_o == last_exp.dir, "R4", "idle position",
                128'(shaft_pos), 128'(last_exp.pos));
          last_exp.step = '0; last_exp.done = 1'b0; last_exp.busy = 1'b0;
        end else begin
          check(step_o == last_exp.step && shaft_pos == last_exp.pos && dir_o == last_exp.dir
                && busy == last_exp.busy && !seg_done, "R3", "hold without tick",
                128'({step_o, seg_done}), 128'({last_exp.step, 1'b0}));
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < NM; m++) begin m_acc[m] = '0; m_rate[m] = '0; m_pos[m] = 0; end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(step_o == '0 && dir_o == '0 && shaft_pos == '0 && !seg_done && !busy,
          "R1", "reset outputs", 128'({step_o, dir_o, seg_done, busy}), 128'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(step_o == '0 && shaft_pos == '0 && !busy, "R1", "after reset release",
          128'({step_o, busy}), 128'(0));

    // R2, R4: constant rate, forward
    run_seg(20, 2'b00, {64'h2000_0000_0000_0000, 64'h4000_0000_0000_0000}, '0);
    drain();
    // R2, R4: acceleration, motor 0 reverse
    run_seg(30, 2'b01, '0, {64'h0200_0000_0000_0000, 64'h0400_0000_0000_0000});
    drain();
    // R7: zero-length segment
    run_seg(0, 2'b10, {2{64'h8000_0000_0000_0000}}, '0);
    drain();
    // R8, R9: back-to-back segments, accumulator carried over
    run_seg(10, 2'b00, {64'h3000_0000_0000_0000, 64'h5555_5555_5555_5555}, '0);
    run_seg(8, 2'b10, {64'h7000_0000_0000_0000, 64'h1000_0000_0000_0000},
            {64'h0100_0000_0000_0000, 64'h0});
    drain();
    // R8: second pending load replaces the first
    run_seg(12, 2'b11, {2{64'h4000_0000_0000_0000}}, '0);
    load_seg(5, 2'b00, {2{64'hF000_0000_0000_0000}}, '0);
    run_seg(6, 2'b01, {64'h9000_0000_0000_0000, 64'h2000_0000_0000_0000}, '0);
    drain();
    // R3: ticks on every other clock
    slow_mode = 1'b1;
    run_seg(15, 2'b10, {64'h1000_0000_0000_0000, 64'h6000_0000_0000_0000},
            {64'h0080_0000_0000_0000, 64'h0});
    drain();
    slow_mode = 1'b0;
    repeat (4) @(negedge clk);
    // R2: maximum rate near wrap
    run_seg(5, 2'b00, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule